// File: doc/BRIEF.md
# Two-Domain Clear Sequencer Half

This block is one end of a clear controller that spans two clock domains. Two copies are wired back to back, one copy in each domain. Each copy drives the isolate and clear controls of the crossing logic in its own domain. Each copy also talks to its peer over a phase channel that uses a toggling request and a toggling acknowledge. A two-bit phase value rides alongside the request.

When software or a local agent raises the clear request, the half acts as initiator. It isolates its side first, then tells the peer to isolate and waits for both to confirm. It then asserts clear on both sides and waits for both to confirm. After that it announces a post-clear phase, in which clear is dropped and isolation is kept. A final idle phase releases isolation. The same half also acts as receiver for sequences its peer starts, and applies each announced phase locally. Its outputs are the OR of what the initiator part and the receiver part demand. The phase encoding is idle 0, isolate 1, clear 2, post-clear 3.

Top module: `clr_seq_half`

## Requirements
- R1: While rst_n is low, iso_o and clr_o both equal the CLEAR_IN_RESET parameter (default 0). After release, tx_req_o, tx_phase_o and rx_ack_o are 0.
- R2: A clr_req_i sampled high at one rising edge, while the half is idle and its outbound channel is quiet, makes iso_o high and toggles tx_req_o with tx_phase_o = 1 after the second rising edge. iso_o is still low after the first edge.
- R3: clr_o is never high while iso_o of the same half is low.
- R4: While either half drives clr_o high, iso_o of both halves is high.
- R5: The initiator announces exactly four phases per sequence, in the order 1, 2, 3, 0, with one tx_req_o toggle each. It changes tx_phase_o only when the synchronized tx_ack_i equals tx_req_o.
- R6: The initiator raises clr_o only after iso_ack_i was high in the previous cycle and the peer has acknowledged the isolate phase.
- R7: A sequence started on either half drives clr_o high on both halves. It ends with iso_o and clr_o low on both halves and the channel quiet.
- R8: In post-clear, the initiator drops clr_o while iso_o stays high on both halves.
- R9: The receiver holds its decoded phase until it toggles rx_ack_o, and toggles rx_ack_o only while the synchronized rx_req_i differs from it. It acknowledges isolate after iso_ack_i, clear after clr_ack_i, and post-clear after clr_ack_i is low.
- R10: A clr_req_i that arrives while a sequence is running is dropped, so no second sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| clr_req_i | input | 1 | Local request to start a clear sequence |
| iso_o | output | 1 | Isolate control to the local crossing logic |
| clr_o | output | 1 | Clear control to the local crossing logic |
| iso_ack_i | input | 1 | Local crossing logic reports isolation done |
| clr_ack_i | input | 1 | Local crossing logic reports clear done |
| tx_req_o | output | 1 | Toggle request of the outbound phase channel |
| tx_phase_o | output | 2 | Phase announced to the peer |
| tx_ack_i | input | 1 | Toggle acknowledge from the peer (asynchronous) |
| rx_req_i | input | 1 | Toggle request from the peer (asynchronous) |
| rx_phase_i | input | 2 | Phase announced by the peer, stable while pending |
| rx_ack_o | output | 1 | Toggle acknowledge to the peer |

## Verification
A wrong initiator state shows at the ports within one local cycle. Either iso_o and clr_o disagree with the phase last placed on tx_phase_o, or tx_req_o toggles a fifth time or out of order. A receiver that decodes a stale phase either holds clr_o high into post-clear, which the cross-half isolation check catches at the next sample of either clock, or never toggles rx_ack_o, which stalls the peer. A stall shows up as a sequence that does not finish within the bound of a few thousand cycles.

// File: rtl/clr_seq_pkg.sv
`timescale 1ns/1ps
// Shared types for the two-domain clear sequencer.
// Assumes both halves agree on the phase encoding below.
package clr_seq_pkg;
    localparam int PHASE_W = 2;

    typedef enum logic [PHASE_W-1:0] {
        PH_IDLE = 2'd0,
        PH_ISO  = 2'd1,
        PH_CLR  = 2'd2,
        PH_POST = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISO,
        ST_CLR,
        ST_POST
    } init_st_e;
endpackage

// File: rtl/clr_seq_sync.sv
`timescale 1ns/1ps
// Flop chain that brings one asynchronous level into the local clock domain.
// Assumes STAGES >= 1; the input must be a glitch-free registered level.
module clr_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    generate
        if (STAGES < 2) begin : g_single
            logic stage_q;
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= 1'b0;
                else        stage_q <= d_i;
            end
            assign q_o = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0] pipe_q;
            // Shift the level through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
            end
            assign q_o = pipe_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/clr_seq_init.sv
`timescale 1ns/1ps
// Initiator: walks isolate, clear, post-clear, idle, and announces each phase
// to the peer over a toggle channel. Assumes ack_s_i is already synchronized.
module clr_seq_init
    import clr_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               iso_ack_i,
    input  logic               clr_ack_i,
    input  logic               ack_s_i,
    output logic               iso_dem_o,
    output logic               clr_dem_o,
    output logic               tx_req_o,
    output logic [PHASE_W-1:0] tx_phase_o
);
    init_st_e state_q;
    phase_e   phase_q;
    logic     req_q;
    logic     start_q;
    logic     chan_quiet;

    assign chan_quiet = (ack_s_i == req_q);

    // Register the request, step the state, and toggle out a new phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            state_q <= ST_IDLE;
            phase_q <= PH_IDLE;
            req_q   <= 1'b0;
        end else begin
            start_q <= start_i;
            unique case (state_q)
                ST_IDLE: if (start_q && chan_quiet) begin
                    state_q <= ST_ISO;
                    phase_q <= PH_ISO;
                    req_q   <= ~req_q;
                end
                ST_ISO: if (iso_ack_i && chan_quiet) begin
                    state_q <= ST_CLR;
                    phase_q <= PH_CLR;
                    req_q   <= ~req_q;
                end
                ST_CLR: if (clr_ack_i && chan_quiet) begin
                    state_q <= ST_POST;
                    phase_q <= PH_POST;
                    req_q   <= ~req_q;
                end
                ST_POST: if (chan_quiet) begin
                    state_q <= ST_IDLE;
                    phase_q <= PH_IDLE;
                    req_q   <= ~req_q;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign iso_dem_o  = (state_q != ST_IDLE);
    assign clr_dem_o  = (state_q == ST_CLR);
    assign tx_req_o   = req_q;
    assign tx_phase_o = phase_q;

    // R5: an unacknowledged phase stays on the wire.
    a_r5_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req_o != ack_s_i) |=> $stable(tx_phase_o));

    // R6: local clear follows local isolation and the peer's confirmation.
    a_r6_clr_after_iso: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr_dem_o) |-> ($past(iso_ack_i) && $past(ack_s_i == tx_req_o)));
endmodule

// File: rtl/clr_seq_recv.sv
`timescale 1ns/1ps
// Receiver: takes each phase the peer announces, applies it locally, and
// toggles the acknowledge once the local crossing logic has confirmed it.
// Assumes req_s_i is synchronized and phase_i is stable while pending.
module clr_seq_recv
    import clr_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_s_i,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               iso_ack_i,
    input  logic               clr_ack_i,
    output logic               iso_dem_o,
    output logic               clr_dem_o,
    output logic               ack_o
);
    phase_e ph_q;
    logic   busy_q;
    logic   ack_q;
    logic   pending;
    logic   done;

    assign pending = (req_s_i != ack_q);

    // Decide when the current phase has taken effect locally.
    always_comb begin
        unique case (ph_q)
            PH_ISO:  done = iso_ack_i;
            PH_CLR:  done = clr_ack_i;
            PH_POST: done = !clr_ack_i;
            default: done = 1'b1;
        endcase
    end

    // Capture a new phase, then acknowledge it when done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            busy_q <= 1'b0;
            ack_q  <= 1'b0;
        end else if (!busy_q && pending) begin
            ph_q   <= phase_e'(phase_i);
            busy_q <= 1'b1;
        end else if (busy_q && done) begin
            ack_q  <= ~ack_q;
            busy_q <= 1'b0;
        end
    end

    assign iso_dem_o = (ph_q != PH_IDLE);
    assign clr_dem_o = (ph_q == PH_CLR);
    assign ack_o     = ack_q;

    // R9: no acknowledge without an outstanding request.
    a_r9_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (req_s_i == ack_o) |=> $stable(ack_o));

    // R9: the applied phase holds until it is acknowledged.
    a_r9_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(ph_q));
endmodule

// File: rtl/clr_seq_half.sv
`timescale 1ns/1ps
// One half of a two-domain clear sequencer: initiator plus receiver, with
// synchronizers on the incoming toggles. Outputs OR both parts' demands.
// Assumes the peer's phase bus is held stable while its request is pending.
module clr_seq_half
    import clr_seq_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter bit CLEAR_IN_RESET = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_req_i,
    output logic               iso_o,
    output logic               clr_o,
    input  logic               iso_ack_i,
    input  logic               clr_ack_i,
    output logic               tx_req_o,
    output logic [PHASE_W-1:0] tx_phase_o,
    input  logic               tx_ack_i,
    input  logic               rx_req_i,
    input  logic [PHASE_W-1:0] rx_phase_i,
    output logic               rx_ack_o
);
    logic ack_s, req_s;
    logic i_iso, i_clr, r_iso, r_clr;

    clr_seq_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
        .clk(clk), .rst_n(rst_n), .d_i(tx_ack_i), .q_o(ack_s));

    clr_seq_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
        .clk(clk), .rst_n(rst_n), .d_i(rx_req_i), .q_o(req_s));

    clr_seq_init i_init (
        .clk(clk), .rst_n(rst_n), .start_i(clr_req_i),
        .iso_ack_i(iso_ack_i), .clr_ack_i(clr_ack_i), .ack_s_i(ack_s),
        .iso_dem_o(i_iso), .clr_dem_o(i_clr),
        .tx_req_o(tx_req_o), .tx_phase_o(tx_phase_o));

    clr_seq_recv i_recv (
        .clk(clk), .rst_n(rst_n), .req_s_i(req_s), .phase_i(rx_phase_i),
        .iso_ack_i(iso_ack_i), .clr_ack_i(clr_ack_i),
        .iso_dem_o(r_iso), .clr_dem_o(r_clr), .ack_o(rx_ack_o));

    // Merge both demands; reset forces the parameter-selected level.
    always_comb begin
        if (!rst_n) begin
            iso_o = CLEAR_IN_RESET;
            clr_o = CLEAR_IN_RESET;
        end else begin
            iso_o = i_iso | r_iso;
            clr_o = i_clr | r_clr;
        end
    end

    // R3: clear only under isolation.
    a_r3_clr_under_iso: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |-> iso_o);
endmodule

// File: tb/test_clr_seq_half.sv
`timescale 1ns/1ps
module test_clr_seq_half;
    logic a_clk = 1'b0, b_clk = 1'b0;
    logic a_rst_n = 1'b0, b_rst_n = 1'b0, h_rst_n = 1'b0;
    always #2.5  a_clk = ~a_clk;
    always #3.65 b_clk = ~b_clk;

    logic a_req = 1'b0, b_req = 1'b0;
    logic a_iso, a_clr, b_iso, b_clr;
    logic a_txr, b_txr, a_rxa, b_rxa;
    logic [1:0] a_txp, b_txp;
    logic a_iso_ack, a_clr_ack, b_iso_ack, b_clr_ack;
    logic [3:0] a_iso_sr, a_clr_sr, b_iso_sr, b_clr_sr;
    int dly = 1;

    logic h_iso, h_clr, h_txr, h_rxa;
    logic [1:0] h_txp;

    clr_seq_half i_clr_seq_half (
        .clk(a_clk), .rst_n(a_rst_n), .clr_req_i(a_req),
        .iso_o(a_iso), .clr_o(a_clr), .iso_ack_i(a_iso_ack), .clr_ack_i(a_clr_ack),
        .tx_req_o(a_txr), .tx_phase_o(a_txp), .tx_ack_i(b_rxa),
        .rx_req_i(b_txr), .rx_phase_i(b_txp), .rx_ack_o(a_rxa));

    clr_seq_half i_clr_seq_half_b (
        .clk(b_clk), .rst_n(b_rst_n), .clr_req_i(b_req),
        .iso_o(b_iso), .clr_o(b_clr), .iso_ack_i(b_iso_ack), .clr_ack_i(b_clr_ack),
        .tx_req_o(b_txr), .tx_phase_o(b_txp), .tx_ack_i(a_rxa),
        .rx_req_i(a_txr), .rx_phase_i(a_txp), .rx_ack_o(b_rxa));

    clr_seq_half #(.CLEAR_IN_RESET(1'b1)) i_clr_seq_half_hold (
        .clk(a_clk), .rst_n(h_rst_n), .clr_req_i(1'b0),
        .iso_o(h_iso), .clr_o(h_clr), .iso_ack_i(1'b0), .clr_ack_i(1'b0),
        .tx_req_o(h_txr), .tx_phase_o(h_txp), .tx_ack_i(1'b0),
        .rx_req_i(1'b0), .rx_phase_i(2'b00), .rx_ack_o(h_rxa));

    // Local crossing-logic models: acknowledge dly cycles after the request.
    always @(posedge a_clk) begin
        if (!a_rst_n) begin a_iso_sr <= '0; a_clr_sr <= '0; end
        else begin a_iso_sr <= {a_iso_sr[2:0], a_iso}; a_clr_sr <= {a_clr_sr[2:0], a_clr}; end
    end
    always @(posedge b_clk) begin
        if (!b_rst_n) begin b_iso_sr <= '0; b_clr_sr <= '0; end
        else begin b_iso_sr <= {b_iso_sr[2:0], b_iso}; b_clr_sr <= {b_clr_sr[2:0], b_clr}; end
    end
    assign a_iso_ack = a_iso_sr[dly-1];
    assign a_clr_ack = a_clr_sr[dly-1];
    assign b_iso_ack = b_iso_sr[dly-1];
    assign b_clr_ack = b_clr_sr[dly-1];

    int n_chk = 0, n_bad = 0;
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitors: invariants, clear edges, and phase announcements.
    int inv_bad = 0, r6_bad = 0, post_bad = 0;
    bit a_seen = 0, b_seen = 0;
    logic [1:0] a_log [8];
    logic [1:0] b_log [8];
    int a_n = 0, b_n = 0;
    logic a_prev_req = 0, a_prev_clr = 0, a_prev_ack = 0;
    logic b_prev_req = 0, b_prev_clr = 0, b_prev_ack = 0;

    always @(negedge a_clk) begin
        if (a_rst_n && b_rst_n) begin
            if (a_clr && !a_iso) inv_bad++;                              // R3
            if ((a_clr || b_clr) && !(a_iso && b_iso)) inv_bad++;        // R4
            if (a_clr) a_seen = 1;
            if (a_clr && !a_prev_clr && !(a_prev_ack && b_iso)) r6_bad++; // R6
            if (!a_clr && a_prev_clr && !(a_iso && b_iso)) post_bad++;   // R8
            if (a_txr !== a_prev_req) begin
                if (a_n < 8) a_log[a_n] = a_txp;
                a_n++;
            end
        end
        a_prev_req = a_txr; a_prev_clr = a_clr; a_prev_ack = a_iso_ack;
    end

    always @(negedge b_clk) begin
        if (a_rst_n && b_rst_n) begin
            if (b_clr && !b_iso) inv_bad++;
            if ((a_clr || b_clr) && !(a_iso && b_iso)) inv_bad++;
            if (b_clr) b_seen = 1;
            if (b_clr && !b_prev_clr && !(b_prev_ack && a_iso)) r6_bad++;
            if (!b_clr && b_prev_clr && !(a_iso && b_iso)) post_bad++;
            if (b_txr !== b_prev_req) begin
                if (b_n < 8) b_log[b_n] = b_txp;
                b_n++;
            end
        end
        b_prev_req = b_txr; b_prev_clr = b_clr; b_prev_ack = b_iso_ack;
    end

    task automatic tick(input bit s);
        if (s) @(negedge b_clk);
        else   @(negedge a_clk);
    endtask

    task automatic set_req(input bit s, input logic v);
        if (s) b_req = v;
        else   a_req = v;
    endtask

    function automatic logic f_iso(input bit s);  return s ? b_iso : a_iso; endfunction
    function automatic logic f_txr(input bit s);  return s ? b_txr : a_txr; endfunction
    function automatic int   f_txp(input bit s);  return s ? int'(b_txp) : int'(a_txp); endfunction
    function automatic logic f_rack(input bit s); return s ? a_rxa : b_rxa; endfunction

    // Vector table: {start side (1 = B), extra request mid-sequence, ack delay}.
    localparam logic [5:0] ROWS [0:5] = '{
        6'b0_0_0001, 6'b1_0_0001, 6'b0_0_0011,
        6'b1_0_0010, 6'b0_1_0010, 6'b1_1_0011
    };

    bit finished = 0;

    initial begin
        repeat (5) @(negedge a_clk);
        chk(a_iso == 0 && a_clr == 0, "R1 reset iso/clr A", int'({a_iso, a_clr}), 0);
        chk(b_iso == 0 && b_clr == 0, "R1 reset iso/clr B", int'({b_iso, b_clr}), 0);
        chk(h_iso == 1 && h_clr == 1, "R1 reset hold variant", int'({h_iso, h_clr}), 3);
        a_rst_n = 1; h_rst_n = 1;
        @(negedge b_clk); b_rst_n = 1;
        repeat (4) @(negedge a_clk);
        chk(a_txr == 0 && a_txp == 0 && a_rxa == 0, "R1 channel idle A", int'({a_txr, a_txp, a_rxa}), 0);
        chk(b_txr == 0 && b_txp == 0 && b_rxa == 0, "R1 channel idle B", int'({b_txr, b_txp, b_rxa}), 0);
        chk(h_iso == 0 && h_clr == 0, "R1 hold variant released", int'({h_iso, h_clr}), 0);

        for (int r = 0; r < 6; r++) begin
            bit s, ex, ok_log, done;
            logic old;
            s  = ROWS[r][5];
            ex = ROWS[r][4];
            dly = int'(ROWS[r][3:0]);
            inv_bad = 0; r6_bad = 0; post_bad = 0;
            a_seen = 0; b_seen = 0; a_n = 0; b_n = 0;
            old = f_txr(s);
            tick(s); set_req(s, 1'b1);
            tick(s); set_req(s, 1'b0);
            chk(f_iso(s) == 0, "R2 iso still low after first edge", int'(f_iso(s)), 0);
            tick(s);
            chk(f_iso(s) == 1 && f_txp(s) == 1 && f_txr(s) != old,
                "R2 isolate announced after second edge", f_txp(s), 1);
            if (ex) begin
                repeat (6) tick(s);
                set_req(s, 1'b1); tick(s); set_req(s, 1'b0);
            end
            done = 0;
            for (int w = 0; w < 4000 && !done; w++) begin
                tick(s);
                done = (f_txp(s) == 0) && (f_txr(s) == f_rack(s)) &&
                       !a_iso && !b_iso && !a_clr && !b_clr;
            end
            chk(done, "R7 sequence completes on both halves", int'(done), 1);
            repeat (40) tick(s);
            chk(a_seen && b_seen, "R7 clear reached both halves", int'({a_seen, b_seen}), 3);
            if (s) begin
                ok_log = (b_n == 4) && b_log[0] == 2'd1 && b_log[1] == 2'd2 &&
                         b_log[2] == 2'd3 && b_log[3] == 2'd0;
                chk(ok_log, ex ? "R5 R10 phase order, single sequence" : "R5 phase order", b_n, 4);
                chk(a_n == 0, "R10 peer announced nothing", a_n, 0);
            end else begin
                ok_log = (a_n == 4) && a_log[0] == 2'd1 && a_log[1] == 2'd2 &&
                         a_log[2] == 2'd3 && a_log[3] == 2'd0;
                chk(ok_log, ex ? "R5 R10 phase order, single sequence" : "R5 phase order", a_n, 4);
                chk(b_n == 0, "R10 peer announced nothing", b_n, 0);
            end
            chk(inv_bad == 0, "R3 R4 isolation invariants", inv_bad, 0);
            chk(r6_bad == 0, "R6 clear after isolate ack", r6_bad, 0);
            chk(post_bad == 0, "R8 isolate kept when clear drops", post_bad, 0);
            chk(f_txr(s) == f_rack(s), "R9 receiver ack matches request", int'(f_rack(s)), int'(f_txr(s)));
            chk(a_iso == 0 && b_iso == 0 && a_clr == 0 && b_clr == 0,
                "R7 all controls released", int'({a_iso, b_iso, a_clr, b_clr}), 0);
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge a_clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R7 watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule